// File: doc/BRIEF.md
# Station Address Match Filter

This block keeps a small set of programmable 48-bit station addresses. It checks the destination field at the head of each received frame against all of them at once. Software loads every address as two 32-bit register writes. The lower word holds the first four destination bytes, and the upper word holds the last two. Loading the lower word takes the pair out of service. Loading the upper word puts it back in service. Because of this ordering, an address that has only been partly rewritten can never produce a match.

The receive side gives the block one destination byte per valid cycle. The first byte is flagged with a start strobe, and idle cycles between bytes are allowed. The block compares each byte against every programmed address as the byte arrives. One cycle after the sixth byte it raises a result strobe. With that strobe it reports whether any pair matched, together with the index of the matching pair. When several pairs match, the lowest index wins. Register writes are accepted at any moment, including while a frame is being received.

Top module: `station_addr_filter`

## Requirements
- R1: After reset every pair is out of service, `match_valid` is low, and a complete frame produces a result with `match_hit` low, whatever its destination bytes are.
- R2: `reg_addr[2:1]` selects the pair. `reg_addr[0]` selects the word: 0 is the lower word and 1 is the upper word.
  - Lower word: destination byte i (i = 0..3) sits in bits 8i+7:8i.
  - Upper word: bits 7:0 hold byte 4 and bits 15:8 hold byte 5. Bits 31:16 of an upper-word write have no effect on matching.
- R3: A lower-word write takes its pair out of service from the next cycle. While the pair is out of service it cannot match, whatever address it holds.
- R4: An upper-word write puts its pair in service from the next cycle, using the address made up of both words.
- R5: A frame starts with a cycle in which `rx_valid` and `rx_sof` are both high. Only cycles with `rx_valid` high carry bytes.
  - `match_valid` is high for exactly one cycle, the cycle after the sixth byte is accepted.
  - Idle cycles between bytes do not change the result.
- R6: `match_hit` is high exactly when an in-service pair equals the destination in all six bytes. `match_idx` then gives that pair's index.
- R7: When more than one in-service pair matches, `match_idx` reports the lowest index.
- R8: A pair that is out of service in any cycle from the start byte through the sixth byte cannot match that frame, even if it is back in service before the frame ends.
- R9: Valid bytes that follow the sixth byte without a new start strobe produce no further result. A start strobe in the middle of a frame discards the partial frame and begins a new one.
- R10: While `match_valid` is low, `match_hit` and `match_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Pair index in bits 2:1, word select in bit 0 (1 = upper) |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | A destination byte is present on `rx_data` |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_data | input | 8 | Destination byte |
| match_valid | output | 1 | One-cycle result strobe |
| match_hit | output | 1 | Some in-service pair matched |
| match_idx | output | 2 | Lowest matching pair index |

## Verification
The assertions watch the service-state handshake on every cycle:
- a lower-word write drops its pair out of service on the next cycle, and an upper-word write restores it;
- a reported hit always names a pair that was in service, and whose top byte equaled the last byte, in the cycle of that byte;
- the result strobe is a single-cycle pulse that follows an accepted byte and never carries a hit when it is low.

The ordering effects can only be shown by the bench's scenarios:
- that a disarm in the middle of a frame spoils that frame, even after the pair is re-armed;
- lowest-index selection between duplicate addresses;
- restart on a new start strobe;
- that every single-bit difference in each of the six bytes defeats a match.

// File: rtl/saf_pkg.sv
`timescale 1ns/1ps
package saf_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = BYTE_W * MAC_BYTES;
    localparam int REG_W     = 32;
    localparam int HI_W      = MAC_W - REG_W;
    localparam int POS_W     = $clog2(MAC_BYTES + 1);

    typedef logic [MAC_W-1:0]  mac_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/saf_regs.sv
`timescale 1ns/1ps
module saf_regs
    import saf_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic                          wr_top,
    input  logic [REG_W-1:0]              wr_data,
    output mac_t [NUM_SLOTS-1:0]          mac_o,
    output logic [NUM_SLOTS-1:0]          armed_o
);
    typedef struct packed {
        mac_t [NUM_SLOTS-1:0]   mac;
        logic [NUM_SLOTS-1:0]   armed;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_top) begin
                // upper word: last two destination bytes, pair re-enters service
                regs_d.mac[wr_slot][MAC_W-1:REG_W] = wr_data[HI_W-1:0];
                regs_d.armed[wr_slot]              = 1'b1;
            end else begin
                // lower word: first four bytes, pair leaves service
                regs_d.mac[wr_slot][REG_W-1:0] = wr_data;
                regs_d.armed[wr_slot]          = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mac_o   = regs_q.mac;
    assign armed_o = regs_q.armed;
endmodule

// File: rtl/saf_byte_cmp.sv
`timescale 1ns/1ps
module saf_byte_cmp
    import saf_pkg::*;
(
    input  mac_t             mac,
    input  logic [POS_W-1:0] pos,
    input  byte_t            data,
    output logic             eq
);
    byte_t sel;

    always_comb begin
        sel = '0;
        for (int b = 0; b < MAC_BYTES; b++) begin
            if (pos == POS_W'(b)) begin
                sel = mac[b*BYTE_W +: BYTE_W];
            end
        end
        eq = (sel == data);
    end
endmodule

// File: rtl/saf_prio.sv
`timescale 1ns/1ps
module saf_prio #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        hit = |req;
    end
endmodule

// File: rtl/station_addr_filter.sv
`timescale 1ns/1ps
module station_addr_filter
    import saf_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [SLOT_W:0]       reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic [BYTE_W-1:0]     rx_data,
    output logic                  match_valid,
    output logic                  match_hit,
    output logic [SLOT_W-1:0]     match_idx
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(MAC_BYTES - 1);

    typedef struct packed {
        logic                  busy;
        logic [POS_W-1:0]      pos;
        logic [NUM_SLOTS-1:0]  ok;
        logic                  res_valid;
    } frame_t;

    frame_t                 st_d, st_q;
    mac_t [NUM_SLOTS-1:0]   slot_mac;
    logic [NUM_SLOTS-1:0]   slot_armed;
    logic [NUM_SLOTS-1:0]   byte_eq;
    logic [POS_W-1:0]       byte_pos;
    logic                   start;
    logic                   any_ok;
    logic [SLOT_W-1:0]      first_ok;

    saf_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_slot (reg_addr[SLOT_W:1]),
        .wr_top  (reg_addr[0]),
        .wr_data (reg_wdata),
        .mac_o   (slot_mac),
        .armed_o (slot_armed)
    );

    assign start    = rx_valid && rx_sof;
    assign byte_pos = start ? '0 : st_q.pos;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        saf_byte_cmp u_cmp (
            .mac  (slot_mac[k]),
            .pos  (byte_pos),
            .data (rx_data),
            .eq   (byte_eq[k])
        );
    end

    saf_prio #(.N(NUM_SLOTS)) u_prio (
        .req (st_q.ok),
        .hit (any_ok),
        .idx (first_ok)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.pos  = POS_W'(1);
            st_d.ok   = slot_armed & byte_eq;
        end else if (st_q.busy) begin
            // any cycle out of service inside the frame spoils the pair
            st_d.ok = st_q.ok & slot_armed;
            if (rx_valid) begin
                st_d.ok = st_d.ok & byte_eq;
                if (st_q.pos == LAST_POS) begin
                    st_d.busy      = 1'b0;
                    st_d.pos       = '0;
                    st_d.res_valid = 1'b1;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_valid = st_q.res_valid;
    assign match_hit   = st_q.res_valid & any_ok;
    assign match_idx   = st_q.res_valid ? first_ok : '0;
endmodule

// File: rtl/saf_checker.sv
`timescale 1ns/1ps
module saf_checker
    import saf_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [SLOT_W:0]       reg_addr,
    input logic                  rx_valid,
    input logic [BYTE_W-1:0]     rx_data,
    input logic                  match_valid,
    input logic                  match_hit,
    input logic [SLOT_W-1:0]     match_idx,
    input logic [NUM_SLOTS-1:0]  armed,
    input mac_t [NUM_SLOTS-1:0]  mac
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |=> !match_valid);

    a_r5_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(rx_valid));

    a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> match_valid);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        a_r3_lower_disarms: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == {SLOT_W'(k), 1'b0}) |=> !armed[k]);

        a_r4_upper_arms: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == {SLOT_W'(k), 1'b1}) |=> armed[k]);

        a_r8_hit_was_armed: assert property (@(posedge clk) disable iff (!rst_n)
            (match_hit && match_idx == SLOT_W'(k)) |-> $past(armed[k]));

        a_r6_last_byte_equal: assert property (@(posedge clk) disable iff (!rst_n)
            (match_hit && match_idx == SLOT_W'(k)) |->
                $past(rx_data) == $past(mac[k][MAC_W-1 -: BYTE_W]));
    end
endmodule

bind station_addr_filter saf_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .match_valid (match_valid),
    .match_hit   (match_hit),
    .match_idx   (match_idx),
    .armed       (slot_armed),
    .mac         (slot_mac)
);

// File: tb/sim_station_addr_filter.sv
`timescale 1ns/1ps
module sim_station_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        match_valid;
    logic        match_hit;
    logic [1:0]  match_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] m_mac [4];
    bit          m_armed [4];

    always #2.5 clk = ~clk;

    station_addr_filter u0 (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .rx_valid (rx_valid), .rx_sof (rx_sof),
        .rx_data (rx_data), .match_valid (match_valid), .match_hit (match_hit),
        .match_idx (match_idx)
    );

    function automatic logic [47:0] addr_of(int k);
        return 48'hA1B2_C3D4_E5F6 ^ (48'h0101_0101_0101 * (k + 1));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(int slot, bit top, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = {slot[1:0], top}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (top) begin m_mac[slot][47:32] = d[15:0]; m_armed[slot] = 1'b1; end
        else     begin m_mac[slot][31:0]  = d;       m_armed[slot] = 1'b0; end
    endtask

    task automatic load(int slot, logic [47:0] a, logic [15:0] junk);
        reg_write(slot, 1'b0, a[31:0]);
        reg_write(slot, 1'b1, {junk, a[47:32]});
    endtask

    function automatic int model_idx(logic [47:0] dest);
        for (int k = 0; k < 4; k++)
            if (m_armed[k] && m_mac[k] == dest) return k;
        return -1;
    endfunction

    // drives six bytes; returns at the negedge where the result is visible
    task automatic send(logic [47:0] dest, int gap);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = dest[8*i +: 8];
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0;
            if (i < 5) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic expect_result(string req, int exp_idx);
        check({req, " valid"}, int'(match_valid), 1);
        check({req, " hit"}, int'(match_hit), int'(exp_idx >= 0));
        check({req, " idx"}, int'(match_idx), exp_idx >= 0 ? exp_idx : 0);
        @(negedge clk);
        check("R5 pulse ends", int'(match_valid), 0);
        check("R10 idle hit/idx", int'({match_hit, match_idx}), 0);
    endtask

    task automatic frame(string req, logic [47:0] dest, int gap);
        send(dest, gap);
        expect_result(req, model_idx(dest));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_mac[k] = '0; m_armed[k] = 1'b0; end
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(match_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: registers hold zero but are out of service
        send(48'h0, 0);
        expect_result("R1 zero frame", -1);

        // R3 / R4: lower word alone does not arm
        for (int k = 0; k < 4; k++) begin
            reg_write(k, 1'b0, addr_of(k)[31:0]);
            send(addr_of(k), 0);
            expect_result("R3 lower only", -1);
            reg_write(k, 1'b1, {16'hBEEF ^ 16'(k), addr_of(k)[47:32]}); // R2 junk upper
            frame("R4 armed R2 map", addr_of(k), 0);
        end

        // R6: every single-bit difference defeats the match
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 48; b++) begin
                send(addr_of(k) ^ (48'h1 << b), 0);
                expect_result("R6 bit flip", -1);
            end

        // R5: idle cycles between bytes
        frame("R5 gaps", addr_of(2), 3);

        // R7: duplicates resolve to lowest index
        load(3, addr_of(1), 16'h0);
        send(addr_of(1), 0); expect_result("R7 dup 1/3", 1);
        load(0, addr_of(1), 16'h0);
        send(addr_of(1), 1); expect_result("R7 dup 0/1/3", 0);
        load(0, addr_of(0), 16'h0);
        load(3, addr_of(3), 16'h0);

        // R3: rewriting lower word with new value stops old and new match
        reg_write(1, 1'b0, 32'h1234_5678);
        send(addr_of(1), 0); expect_result("R3 old addr", -1);
        send({addr_of(1)[47:32], 32'h1234_5678}, 0); expect_result("R3 new half", -1);
        load(1, addr_of(1), 16'h0);

        // R8: disarm then re-arm during a frame
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = addr_of(2)[8*i +: 8];
            if (i == 2) begin reg_wr = 1'b1; reg_addr = 3'b100; reg_wdata = addr_of(2)[31:0]; end
            if (i == 3) begin reg_wr = 1'b1; reg_addr = 3'b101; reg_wdata = {16'h0, addr_of(2)[47:32]}; end
            @(negedge clk);
            reg_wr = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0;
        end
        expect_result("R8 mid-frame disarm", -1);
        frame("R8 rearmed next frame", addr_of(2), 0);

        // R9: trailing bytes produce nothing more
        send(addr_of(3), 0);
        check("R9 result", int'(match_hit), 1);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_data = addr_of(3)[8*i +: 8];
            @(negedge clk);
            check("R9 no extra result", int'(match_valid), 0);
        end
        rx_valid = 1'b0;
        // R9: restart on a new start strobe
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = addr_of(1)[8*i +: 8];
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
        send(addr_of(0), 0);
        expect_result("R9 restart", 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule